// File: doc/BRIEF.md
# Four-Channel DMA Address and Count Engine

This block holds the programming state of a four-channel direct memory access controller and serves address requests from the agents that move the data. A host programs it one byte at a time through a 4-bit register port. Through that port it loads a 16-bit start address and a 16-bit transfer count for each channel, sets each channel's transfer direction and step direction, and handles the request and mask bits. It also reads back status. A separate 3-bit port writes and reads an eight-entry file of page bytes, which supply the upper eight bits of every memory address.

A data mover asks for the next address of a channel by raising `req_valid` with the channel number and the direction it wants. The core accepts a request every cycle. One cycle later it answers with a flag and, when the flag is set, a 24-bit address. The address is the channel's page byte above its current 16-bit address. When the request is served, the channel's address steps by one and its count drops by one. When the count passes from zero to 0xFFFF, the channel's terminal-count (TC) flag is raised, and a channel with TC set refuses all further requests.

The byte pointer is a two-state machine shared by all four channels. In state LOW, any read or write of ports 0 to 7 moves it to HIGH. In state HIGH, any such access moves it back to LOW. A write to port 0xC or port 0xD sends it to LOW from either state. Reset places it in LOW.

Top module: `dma4_core`

## Requirements
- R1: Ports 0 to 7 select channel `reg_addr[2:1]`. An even port reaches that channel's address register and an odd port reaches its count register. The byte pointer picks which byte: state LOW reaches bits [7:0] and state HIGH reaches bits [15:8].
- R2: One byte pointer is shared by all channels and by both register kinds. It toggles on every read or write of ports 0 to 7. A write to port 0xC returns it to LOW.
- R3: A write to port 8 stores the full command byte. Reading port 0xE returns that byte. No command bit, the enable bit 2 included, changes the answers to transfer requests.
- R4: Reading port 8 returns status, with TC flags of channels 0..3 in bits 3:0 and request flags in bits 7:4. That read clears all four TC flags at the clock edge. A TC set in the same cycle by a transfer takes priority over the clear.
- R5: A write to port 9 sets or clears the request bit of channel `wdata[1:0]`, according to `wdata[2]`. A write to port 0xA does the same for that channel's mask bit. A write to port 0xF loads all masks from `wdata[3:0]`. Reading port 0xF returns the masks in bits 3:0. Masks do not affect transfer requests.
- R6: A write to port 0xB sets the mode of channel `wdata[1:0]`. Bits 3:2 give the transfer type: 0 is verify, 1 is write, 2 is read and 3 is invalid. Bit 5 set makes the address step down, and clear makes it step up.
- R7: A write to port 0xD is a master clear. It returns the pointer to LOW, sets all masks and all TC flags, and clears all request bits. A write to port 0xE clears all masks.
- R8: A request is refused when the channel's TC flag is set, or when its direction does not match the type (write needs type 1, read needs type 2). A refusal gives `rsp_ok`=0 and `rsp_addr`=0, and leaves address and count unchanged.
- R9: A served request returns the current address. It then steps the address by +1 or -1 and decrements the count. A count that passes from 0x0000 to 0xFFFF sets the channel's TC flag.
- R10: Page port p writes slot s, with ports 7,3,1,2,0,4,5,6 mapping to slots 0..7. Channel c uses slot c. `rsp_addr` is {page, 16-bit address}. `page_rdata` returns the byte written through `page_addr`.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R12: After reset, the pointer is in LOW, all masks and TC flags are set, and requests, addresses, counts, modes, command and pages are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Register port number |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte, combinational |
| page_wr | input | 1 | Page write strobe |
| page_addr | input | 3 | Page port number |
| page_wdata | input | 8 | Page write byte |
| page_rdata | output | 8 | Page read byte, combinational |
| req_valid | input | 1 | Transfer request |
| req_chan | input | 2 | Requesting channel |
| req_write | input | 1 | 1 = write-to-memory request, 0 = read |
| rsp_valid | output | 1 | Answer to last cycle's request |
| rsp_ok | output | 1 | Request served |
| rsp_addr | output | 24 | Served memory address |

## Verification
A pointer left in the wrong state shows up on the very next byte read of ports 0 to 7, as the swapped half of a known register. A TC flag that is missed or cleared wrongly shows up on the next request to that channel, as a refusal or an extra served address. It also shows in the next status read. Wrong stepping or a wrong page map shows up in the `rsp_addr` of the following request, one cycle after it is issued.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = 16;
    localparam int PAGE_W = 8;
    localparam int NPAGE  = 8;
    localparam int MEM_W  = PAGE_W + CH_W;

    typedef enum logic [1:0] {
        XT_VERIFY  = 2'd0,
        XT_WRITE   = 2'd1,
        XT_READ    = 2'd2,
        XT_INVALID = 2'd3
    } xfer_t;

    typedef enum logic {
        PTR_LOW  = 1'b0,
        PTR_HIGH = 1'b1
    } ptr_t;

    localparam logic [3:0] P_CMD_STAT = 4'h8;
    localparam logic [3:0] P_REQ      = 4'h9;
    localparam logic [3:0] P_MASK1    = 4'hA;
    localparam logic [3:0] P_MODE     = 4'hB;
    localparam logic [3:0] P_PTRCLR   = 4'hC;
    localparam logic [3:0] P_MCLR     = 4'hD;
    localparam logic [3:0] P_MASKCLR  = 4'hE;
    localparam logic [3:0] P_MASKALL  = 4'hF;

    // page port number -> storage slot (slot index equals channel)
    function automatic logic [2:0] page_slot(input logic [2:0] port);
        unique case (port)
            3'd7: page_slot = 3'd0;
            3'd3: page_slot = 3'd1;
            3'd1: page_slot = 3'd2;
            3'd2: page_slot = 3'd3;
            3'd0: page_slot = 3'd4;
            3'd4: page_slot = 3'd5;
            3'd5: page_slot = 3'd6;
            default: page_slot = 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic            ld_cnt,
    input  logic            ld_hi,
    input  logic [7:0]      ld_data,
    input  logic            mode_we,
    input  logic [1:0]      mode_type,
    input  logic            mode_decr,
    input  logic            req_we,
    input  logic            req_val,
    input  logic            mask_we,
    input  logic            mask_val,
    input  logic            mclr,
    input  logic            mask_clr_all,
    input  logic            tc_clr,
    input  logic            step,
    output logic [CH_W-1:0] addr,
    output logic [CH_W-1:0] cnt,
    output logic            tc,
    output logic            req,
    output logic            mask,
    output logic            wr_ok,
    output logic            rd_ok
);
    xfer_t xtype_q;
    logic  decr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            cnt     <= '0;
            xtype_q <= XT_VERIFY;
            decr_q  <= 1'b0;
        end else begin
            if (ld_en) begin
                if (ld_cnt) begin
                    if (ld_hi) cnt[CH_W-1:8] <= ld_data;
                    else       cnt[7:0]      <= ld_data;
                end else begin
                    if (ld_hi) addr[CH_W-1:8] <= ld_data;
                    else       addr[7:0]      <= ld_data;
                end
            end else if (step) begin
                addr <= decr_q ? addr - 1'b1 : addr + 1'b1;
                cnt  <= cnt - 1'b1;
            end
            if (mode_we) begin
                xtype_q <= xfer_t'(mode_type);
                decr_q  <= mode_decr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc   <= 1'b1;
            req  <= 1'b0;
            mask <= 1'b1;
        end else begin
            if (mclr)                    tc <= 1'b1;
            else if (step && cnt == '0)  tc <= 1'b1;
            else if (tc_clr)             tc <= 1'b0;

            if (mclr)        req <= 1'b0;
            else if (req_we) req <= req_val;

            if (mclr)              mask <= 1'b1;
            else if (mask_clr_all) mask <= 1'b0;
            else if (mask_we)      mask <= mask_val;
        end
    end

    assign wr_ok = !tc && (xtype_q == XT_WRITE);
    assign rd_ok = !tc && (xtype_q == XT_READ);
endmodule

// File: rtl/dma4_pages.sv
module dma4_pages
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        port,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] rdata,
    input  logic [2:0]        slot_idx,
    output logic [PAGE_W-1:0] slot_data
);
    logic [NPAGE-1:0][PAGE_W-1:0] slots_q;

    always_ff @(posedge clk) begin
        if (!rst_n) slots_q <= '0;
        else if (we) slots_q[page_slot(port)] <= wdata;
    end

    assign rdata     = slots_q[page_slot(port)];
    assign slot_data = slots_q[slot_idx];
endmodule

// File: rtl/dma4_core.sv
module dma4_core
    import dma4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             page_wr,
    input  logic [2:0]       page_addr,
    input  logic [7:0]       page_wdata,
    output logic [7:0]       page_rdata,
    input  logic             req_valid,
    input  logic [1:0]       req_chan,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [MEM_W-1:0] rsp_addr
);
    ptr_t ptr_q, ptr_d;
    logic ptr_high;
    logic acc_low, ptr_clr, mclr, mask_clr_all, stat_rd;
    logic [7:0] cmd_q;
    logic [NCH-1:0] tc_vec, req_vec, mask_vec, wr_ok_vec, rd_ok_vec, step_vec;
    logic [NCH-1:0][CH_W-1:0] addr_vec, cnt_vec;
    logic [PAGE_W-1:0] chan_page;
    logic sel_ok;

    assign acc_low      = (reg_wr || reg_rd) && !reg_addr[3];
    assign ptr_clr      = reg_wr && (reg_addr == P_PTRCLR || reg_addr == P_MCLR);
    assign mclr         = reg_wr && reg_addr == P_MCLR;
    assign mask_clr_all = reg_wr && reg_addr == P_MASKCLR;
    assign stat_rd      = reg_rd && reg_addr == P_CMD_STAT;
    assign ptr_high     = (ptr_q == PTR_HIGH);

    // byte pointer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= PTR_LOW;
        else        ptr_q <= ptr_d;
    end

    // byte pointer: next state
    always_comb begin
        ptr_d = ptr_q;
        unique case (ptr_q)
            PTR_LOW:  if (ptr_clr) ptr_d = PTR_LOW;
                      else if (acc_low) ptr_d = PTR_HIGH;
            PTR_HIGH: if (ptr_clr || acc_low) ptr_d = PTR_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else if (reg_wr && reg_addr == P_CMD_STAT) cmd_q <= reg_wdata;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = reg_wdata[1:0] == i[1:0];
        assign step_vec[i] = req_valid && req_chan == i[1:0] &&
                             (req_write ? wr_ok_vec[i] : rd_ok_vec[i]);
        dma4_chan u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .ld_en        (reg_wr && !reg_addr[3] && reg_addr[2:1] == i[1:0]),
            .ld_cnt       (reg_addr[0]),
            .ld_hi        (ptr_high),
            .ld_data      (reg_wdata),
            .mode_we      (reg_wr && reg_addr == P_MODE && hit),
            .mode_type    (reg_wdata[3:2]),
            .mode_decr    (reg_wdata[5]),
            .req_we       (reg_wr && reg_addr == P_REQ && hit),
            .req_val      (reg_wdata[2]),
            .mask_we      (reg_wr && ((reg_addr == P_MASK1 && hit) || reg_addr == P_MASKALL)),
            .mask_val     ((reg_addr == P_MASKALL) ? reg_wdata[i] : reg_wdata[2]),
            .mclr         (mclr),
            .mask_clr_all (mask_clr_all),
            .tc_clr       (stat_rd),
            .step         (step_vec[i]),
            .addr         (addr_vec[i]),
            .cnt          (cnt_vec[i]),
            .tc           (tc_vec[i]),
            .req          (req_vec[i]),
            .mask         (mask_vec[i]),
            .wr_ok        (wr_ok_vec[i]),
            .rd_ok        (rd_ok_vec[i])
        );
    end

    dma4_pages u_pages (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (page_wr),
        .port      (page_addr),
        .wdata     (page_wdata),
        .rdata     (page_rdata),
        .slot_idx  ({1'b0, req_chan}),
        .slot_data (chan_page)
    );

    assign sel_ok = |step_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= sel_ok;
            rsp_addr  <= sel_ok ? {chan_page, addr_vec[req_chan]} : '0;
        end
    end

    // register read outputs
    always_comb begin
        logic [CH_W-1:0] word;
        word = reg_addr[0] ? cnt_vec[reg_addr[2:1]] : addr_vec[reg_addr[2:1]];
        if (!reg_addr[3])                    reg_rdata = ptr_high ? word[CH_W-1:8] : word[7:0];
        else if (reg_addr == P_CMD_STAT)     reg_rdata = {req_vec, tc_vec};
        else if (reg_addr == P_MASKCLR)      reg_rdata = cmd_q;
        else if (reg_addr == P_MASKALL)      reg_rdata = {4'b0, mask_vec};
        else                                 reg_rdata = 8'h00;
    end
endmodule

// File: rtl/dma4_core_chk.sv
module dma4_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic       req_valid,
    input logic       rsp_valid,
    input logic       ptr_high,
    input logic [3:0] tc_vec,
    input logic [3:0] req_vec,
    input logic [3:0] mask_vec
);
    // R11
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && !reg_addr[3]) |=> (ptr_high != $past(ptr_high)));
    // R2
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'hC) |=> !ptr_high);
    // R4
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && !req_valid && reg_addr == 4'h8) |=> (tc_vec == 4'h0));
    // R7
    master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'hD) |=>
        (mask_vec == 4'hF && tc_vec == 4'hF && req_vec == 4'h0 && !ptr_high));
    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'hE) |=> (mask_vec == 4'h0));
endmodule

bind dma4_core dma4_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .ptr_high  (ptr_high),
    .tc_vec    (tc_vec),
    .req_vec   (req_vec),
    .mask_vec  (mask_vec)
);

// File: tb/dma4_core_tb_top.sv
`timescale 1ns/1ps
module dma4_core_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic page_wr = 1'b0;
    logic [2:0] page_addr = '0;
    logic [7:0] page_wdata = '0;
    logic [7:0] page_rdata;
    logic req_valid = 1'b0;
    logic [1:0] req_chan = '0;
    logic req_write = 1'b0;
    logic rsp_valid, rsp_ok;
    logic [23:0] rsp_addr;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        ok;
        logic [23:0] addr;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    dma4_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .page_wr(page_wr), .page_addr(page_addr),
        .page_wdata(page_wdata), .page_rdata(page_rdata),
        .req_valid(req_valid), .req_chan(req_chan), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string r);
        reg_rd = 1'b1; reg_addr = a;
        #1 chk(r, {24'h0, reg_rdata}, {24'h0, exp});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pg_wr(input logic [2:0] p, input logic [7:0] d);
        page_wr = 1'b1; page_addr = p; page_wdata = d;
        @(negedge clk);
        page_wr = 1'b0;
    endtask

    task automatic pg_chk(input logic [2:0] p, input logic [7:0] exp, input string r);
        page_addr = p;
        #1 chk(r, {24'h0, page_rdata}, {24'h0, exp});
        @(negedge clk);
    endtask

    // driver: issue a request and push its expected answer
    task automatic xfer(input logic [1:0] ch, input logic w, input logic ok,
                        input logic [23:0] a, input string r);
        exp_t e;
        e.ok = ok; e.addr = ok ? a : 24'h0; e.tag = r;
        exp_q.push_back(e);
        req_valid = 1'b1; req_chan = ch; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pop and compare each answer
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: actual unexpected response expected none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " ok"}, {31'h0, rsp_ok}, {31'h0, e.ok});
                chk({e.tag, " addr"}, {8'h0, rsp_addr}, {8'h0, e.addr});
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_chk(4'h8, 8'h0F, "R12 status after reset");
        rd_chk(4'h8, 8'h00, "R4 status read cleared TC");
        rd_chk(4'hF, 8'h0F, "R12 masks after reset");
        rd_chk(4'hE, 8'h00, "R12 command after reset");
        pg_chk(3'd4, 8'h00, "R12 page after reset");

        // channel 1: address 0x1234, count 2, write type, stepping up
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        wr(4'h3, 8'h02); wr(4'h3, 8'h00);
        wr(4'hB, 8'h45);
        pg_wr(3'd3, 8'hA5);
        pg_wr(3'd7, 8'h11);
        rd_chk(4'h2, 8'h34, "R1 addr low byte");
        rd_chk(4'h3, 8'h00, "R2 shared pointer reaches count high");
        rd_chk(4'h2, 8'h34, "R2 pointer back to low");
        rd_chk(4'h2, 8'h12, "R1 addr high byte");
        rd_chk(4'h2, 8'h34, "R1 addr low again");
        wr(4'hC, 8'h00);
        rd_chk(4'h2, 8'h34, "R2 pointer clear");

        xfer(2'd1, 1'b0, 1'b0, 24'h0, "R8 direction mismatch");
        xfer(2'd1, 1'b1, 1'b1, 24'hA51234, "R9 first served");
        xfer(2'd1, 1'b1, 1'b1, 24'hA51235, "R9 second served");
        xfer(2'd1, 1'b1, 1'b1, 24'hA51236, "R9 count wrap");
        xfer(2'd1, 1'b1, 1'b0, 24'h0, "R8 refused after TC");
        rd_chk(4'h8, 8'h02, "R9 TC of channel 1");
        wr(4'hC, 8'h00);
        rd_chk(4'h2, 8'h37, "R9 address advanced low");
        rd_chk(4'h2, 8'h12, "R8 address high unchanged");
        rd_chk(4'h3, 8'hFF, "R9 count wrapped low");
        rd_chk(4'h3, 8'hFF, "R9 count wrapped high");

        // channel 0: address 0, count 0, read type, stepping down
        wr(4'hC, 8'h00);
        wr(4'h0, 8'h00); wr(4'h0, 8'h00);
        wr(4'h1, 8'h00); wr(4'h1, 8'h00);
        wr(4'hB, 8'h28);
        xfer(2'd0, 1'b0, 1'b1, 24'h110000, "R10 channel 0 page slot");
        xfer(2'd0, 1'b0, 1'b0, 24'h0, "R9 zero count ends at once");
        rd_chk(4'h8, 8'h01, "R9 TC of channel 0");
        wr(4'hC, 8'h00);
        rd_chk(4'h0, 8'hFF, "R6 decrement low");
        rd_chk(4'h0, 8'hFF, "R6 decrement high");

        // channel 2 in verify type
        wr(4'hB, 8'h02);
        xfer(2'd2, 1'b1, 1'b0, 24'h0, "R8 verify refuses write");
        xfer(2'd2, 1'b0, 1'b0, 24'h0, "R8 verify refuses read");

        // request bits
        wr(4'h9, 8'h07);
        wr(4'h9, 8'h05);
        rd_chk(4'h8, 8'hA0, "R5 requests set");
        wr(4'h9, 8'h01);
        rd_chk(4'h8, 8'h80, "R5 request cleared");

        // masks
        wr(4'hE, 8'h00);
        rd_chk(4'hF, 8'h00, "R7 mask clear all");
        wr(4'hA, 8'h06);
        rd_chk(4'hF, 8'h04, "R5 single mask set");
        wr(4'hF, 8'h09);
        rd_chk(4'hF, 8'h09, "R5 all masks write");
        wr(4'hF, 8'h0F);
        wr(4'hB, 8'h07);
        pg_wr(3'd2, 8'h3C);
        xfer(2'd3, 1'b1, 1'b1, 24'h3C0000, "R5 masked channel still served");

        // command register
        wr(4'h8, 8'hC4);
        rd_chk(4'hE, 8'hC4, "R3 command readback");

        // master clear
        rd_chk(4'h0, 8'hFF, "R1 pointer to high before clear");
        wr(4'hD, 8'h00);
        rd_chk(4'h8, 8'h0F, "R7 master clear status");
        rd_chk(4'hF, 8'h0F, "R7 master clear masks");
        rd_chk(4'h2, 8'h37, "R7 master clear pointer low");

        pg_chk(3'd3, 8'hA5, "R10 page readback port 3");
        pg_chk(3'd7, 8'h11, "R10 page readback port 7");

        repeat (3) @(negedge clk);
        chk("R11 all responses seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule